// File: doc/BRIEF.md
# SCSI Message-In Decoder

This block handles the initiator's side of the message-in phase with manual byte transfer. The target presents a byte on the data lines and raises a request. The decoder reads the byte straight off the lines and decides what it means. Only after that does it acknowledge the byte, with a one-cycle strobe that stands for the dummy read of the latched data. A target cannot send a second byte until the first one has been acknowledged, so each byte is fully processed before the next one arrives.

The decoder recognises command complete, disconnect, save and restore pointers, an incoming reject, IDENTIFY (optionally followed by a simple queue tag), and the synchronous and wide negotiation forms of the extended message. For each one it raises a single-cycle event, and the event's parameters are valid in that same cycle. When a message cannot be accepted, the decoder asks for ATN and hands the message-out logic a one-byte reply: MESSAGE REJECT for bad messages, ABORT TAG for an out-of-range tag. Looking up the command slot and moving data belong to neighbouring blocks.

Top module: `msgin_decoder`

## Requirements
- R1: A first byte of 0x00, 0x04, 0x02, 0x03 or 0x07 raises exactly one of the matching single-cycle events (done, disconnect, save, restore, reject received), together with the acknowledge for that byte. At most one event is raised in any cycle.
- R2: A first byte with bit 7 set is an IDENTIFY. If any of bits 6:3 are set it is rejected. Otherwise the reconnect code reported with it is {reselect ID[3:0], channel bit, byte[2:0]}, from bit 7 down to bit 0.
- R3: After an accepted IDENTIFY, a next byte of 0x20 selects tag capture. Any other next byte ends the IDENTIFY with tag 0xFF; that byte is not acknowledged there and is then decoded as the first byte of a new message. A phase mismatch or bus free at that point also ends the IDENTIFY with tag 0xFF.
- R4: The tag byte is accepted only if adding the 8-bit two's complement of TAG_SLOTS to it gives no carry, which means tag < TAG_SLOTS. An accepted tag is reported with IDENTIFY. A tag that fails raises the abort-tag event with ATN and reply 0x0D, and no IDENTIFY event.
- R5: The bytes 0x01, 0x03, 0x01, P, O raise the sync event with period P and offset O.
- R6: The bytes 0x01, 0x02, 0x03, W raise the wide event with exponent W.
- R7: An extended message whose code is neither 0x01 nor 0x03, or whose length byte does not match its code (3 for 0x01, 2 for 0x03), is rejected when the code byte arrives.
- R8: Rejecting means the send-reject event, ATN and reply valid with reply byte 0x07, all in the same cycle. Any first byte not covered by R1, R2 or 0x01 is rejected this way. ATN always accompanies a valid reply.
- R9: Every byte taken is acknowledged exactly once, in the cycle after the edge that sampled it. No byte is taken again until the request has been seen low after that acknowledge.
- R10: A phase mismatch while a further byte of an extended message or a tag is expected raises the phase-mismatch event with no acknowledge, and the decoder returns to waiting for a first byte.
- R11: The first byte of the most recent message stays readable on first_byte_o.
- R12: After reset all events, acknowledge, ATN and reply valid are low and first_byte_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Byte present on the data lines (request asserted in message-in) |
| data_i | input | 8 | Data lines |
| phase_mis_i | input | 1 | Bus phase no longer message-in |
| bus_free_i | input | 1 | Bus free detected |
| resel_id_i | input | 4 | ID of the reselecting target |
| chan_b_i | input | 1 | Second channel is the active one |
| ack_o | output | 1 | Acknowledge strobe (dummy read of latched byte) |
| atn_o | output | 1 | Request to assert ATN |
| reply_vld_o | output | 1 | Load the one-byte reply |
| reply_byte_o | output | 8 | Reply message byte |
| first_byte_o | output | 8 | First byte of the latest message |
| ev_done_o | output | 1 | Command complete event |
| ev_disc_o | output | 1 | Disconnect event |
| ev_save_o | output | 1 | Save pointers event |
| ev_restore_o | output | 1 | Restore pointers event |
| ev_rej_in_o | output | 1 | Reject received event |
| ev_ident_o | output | 1 | Reconnect identified event |
| ident_tcl_o | output | 8 | Reconnect code (ID, channel, LUN) |
| tag_o | output | 8 | Tag, 0xFF when none |
| ev_sync_o | output | 1 | Sync negotiation received |
| sync_period_o | output | 8 | Transfer period |
| sync_offset_o | output | 8 | REQ/ACK offset |
| ev_wide_o | output | 1 | Wide negotiation received |
| wide_exp_o | output | 8 | Width exponent |
| ev_send_rej_o | output | 1 | Reject being sent |
| ev_abort_tag_o | output | 1 | Abort tag being sent |
| ev_phase_mis_o | output | 1 | Phase changed mid-message |

## Verification
Several properties are checked on every cycle: events are mutually exclusive, each reply travels with ATN and the right code byte, an accepted tag lies within range, acknowledges are spaced apart and always follow a request, and a phase-mismatch event never comes with an acknowledge. What only the bench's scenarios can show is decoding to the right values. That covers which event a given code produces, how the reconnect code is packed, re-decoding the byte that ends a tag snoop, capture of negotiation parameters, and the exact point where a wrong extended length is caught.

// File: rtl/msgin_pkg.sv
package msgin_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t C_DONE       = 8'h00;
  localparam byte_t C_EXT        = 8'h01;
  localparam byte_t C_SAVE       = 8'h02;
  localparam byte_t C_RESTORE    = 8'h03;
  localparam byte_t C_DISC       = 8'h04;
  localparam byte_t C_REJECT     = 8'h07;
  localparam byte_t C_ABORT_TAG  = 8'h0D;
  localparam byte_t C_SIMPLE_TAG = 8'h20;
  localparam byte_t X_SYNC       = 8'h01;
  localparam byte_t X_WIDE       = 8'h03;
  localparam byte_t X_SYNC_LEN   = 8'h03;
  localparam byte_t X_WIDE_LEN   = 8'h02;
  localparam byte_t NO_TAG       = 8'hFF;
  localparam byte_t IDENT_RSVD   = 8'h78;

  typedef enum logic [2:0] {
    K_IDENT, K_DONE, K_DISC, K_SAVE, K_RESTORE, K_EXT, K_REJ_IN, K_UNKNOWN
  } kind_e;

  typedef enum logic [2:0] {
    S_FIRST, S_SNOOP, S_TAG, S_XLEN, S_XCODE, S_XPER, S_XOFS, S_XWID
  } state_e;
endpackage

// File: rtl/msgin_req_gate.sv
module msgin_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic ack_set_i,
  output logic take_o
);
  logic armed_q;
  logic armed_d;

  always_comb begin
    armed_d = armed_q;
    if (ack_set_i)   armed_d = 1'b0;
    else if (!req_i) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= armed_d;
  end

  assign take_o = req_i & armed_q;
endmodule

// File: rtl/msgin_classify.sv
module msgin_classify
  import msgin_pkg::*;
(
  input  byte_t data_i,
  output kind_e kind_o
);
  always_comb begin
    if (data_i[BYTE_W-1]) begin
      kind_o = K_IDENT;
    end else begin
      case (data_i)
        C_DONE:    kind_o = K_DONE;
        C_DISC:    kind_o = K_DISC;
        C_SAVE:    kind_o = K_SAVE;
        C_RESTORE: kind_o = K_RESTORE;
        C_EXT:     kind_o = K_EXT;
        C_REJECT:  kind_o = K_REJ_IN;
        default:   kind_o = K_UNKNOWN;
      endcase
    end
  end
endmodule

// File: rtl/msgin_tag_check.sv
module msgin_tag_check
  import msgin_pkg::*;
#(
  parameter int TAG_SLOTS = 32
) (
  input  byte_t tag_i,
  output logic  in_range_o
);
  localparam int    COMP_INT = (256 - TAG_SLOTS) % 256;
  localparam byte_t COMP     = byte_t'(COMP_INT);

  logic [BYTE_W:0] sum;
  assign sum        = {1'b0, tag_i} + {1'b0, COMP};
  assign in_range_o = ~sum[BYTE_W];
endmodule

// File: rtl/msgin_decoder.sv
module msgin_decoder
  import msgin_pkg::*;
#(
  parameter int TAG_SLOTS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic [7:0] data_i,
  input  logic       phase_mis_i,
  input  logic       bus_free_i,
  input  logic [3:0] resel_id_i,
  input  logic       chan_b_i,
  output logic       ack_o,
  output logic       atn_o,
  output logic       reply_vld_o,
  output logic [7:0] reply_byte_o,
  output logic [7:0] first_byte_o,
  output logic       ev_done_o,
  output logic       ev_disc_o,
  output logic       ev_save_o,
  output logic       ev_restore_o,
  output logic       ev_rej_in_o,
  output logic       ev_ident_o,
  output logic [7:0] ident_tcl_o,
  output logic [7:0] tag_o,
  output logic       ev_sync_o,
  output logic [7:0] sync_period_o,
  output logic [7:0] sync_offset_o,
  output logic       ev_wide_o,
  output logic [7:0] wide_exp_o,
  output logic       ev_send_rej_o,
  output logic       ev_abort_tag_o,
  output logic       ev_phase_mis_o
);
  state_e st_q, st_d;
  byte_t  first_q, first_d, len_q, len_d, per_q, per_d, tcl_q, tcl_d;
  byte_t  reply_q, reply_d, itcl_q, itcl_d, tag_q, tag_d;
  byte_t  sper_q, sper_d, sofs_q, sofs_d, wexp_q, wexp_d;
  logic   ack_q, ack_d, atn_q, atn_d, rvld_q, rvld_d;
  logic   done_q, done_d, disc_q, disc_d, save_q, save_d, rest_q, rest_d;
  logic   rejin_q, rejin_d, ident_q, ident_d, sync_q, sync_d, wide_q, wide_d;
  logic   srej_q, srej_d, abort_q, abort_d, pmis_q, pmis_d;
  logic   take, tag_ok, rej;
  kind_e  kind;

  msgin_req_gate gate_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_set_i(ack_d), .take_o(take)
  );

  msgin_classify cls_i (.data_i(data_i), .kind_o(kind));

  msgin_tag_check #(.TAG_SLOTS(TAG_SLOTS)) tchk_i (.tag_i(data_i), .in_range_o(tag_ok));

  always_comb begin
    st_d = st_q;   first_d = first_q; len_d = len_q;   per_d = per_q;
    tcl_d = tcl_q; reply_d = reply_q; itcl_d = itcl_q; tag_d = tag_q;
    sper_d = sper_q; sofs_d = sofs_q; wexp_d = wexp_q;
    ack_d = 1'b0;  atn_d = 1'b0;  rvld_d = 1'b0; rej = 1'b0;
    done_d = 1'b0; disc_d = 1'b0; save_d = 1'b0; rest_d = 1'b0;
    rejin_d = 1'b0; ident_d = 1'b0; sync_d = 1'b0; wide_d = 1'b0;
    srej_d = 1'b0; abort_d = 1'b0; pmis_d = 1'b0;
    case (st_q)
      S_FIRST: begin
        if (take) begin
          first_d = data_i;
          ack_d   = 1'b1;
          case (kind)
            K_IDENT: begin
              if ((data_i & IDENT_RSVD) != '0) rej = 1'b1;
              else begin
                tcl_d = {resel_id_i, chan_b_i, data_i[2:0]};
                st_d  = S_SNOOP;
              end
            end
            K_DONE:    done_d  = 1'b1;
            K_DISC:    disc_d  = 1'b1;
            K_SAVE:    save_d  = 1'b1;
            K_RESTORE: rest_d  = 1'b1;
            K_REJ_IN:  rejin_d = 1'b1;
            K_EXT:     st_d    = S_XLEN;
            default:   rej     = 1'b1;
          endcase
        end
      end
      S_SNOOP: begin
        if (phase_mis_i || bus_free_i || (take && data_i != C_SIMPLE_TAG)) begin
          ident_d = 1'b1;
          itcl_d  = tcl_q;
          tag_d   = NO_TAG;
          st_d    = S_FIRST;
        end else if (take) begin
          ack_d = 1'b1;
          st_d  = S_TAG;
        end
      end
      S_TAG: begin
        if (phase_mis_i) begin
          pmis_d = 1'b1;
          st_d   = S_FIRST;
        end else if (take) begin
          ack_d = 1'b1;
          st_d  = S_FIRST;
          if (tag_ok) begin
            ident_d = 1'b1;
            itcl_d  = tcl_q;
            tag_d   = data_i;
          end else begin
            abort_d = 1'b1;
            atn_d   = 1'b1;
            rvld_d  = 1'b1;
            reply_d = C_ABORT_TAG;
          end
        end
      end
      default: begin
        if (phase_mis_i) begin
          pmis_d = 1'b1;
          st_d   = S_FIRST;
        end else if (take) begin
          ack_d = 1'b1;
          st_d  = S_FIRST;
          case (st_q)
            S_XLEN: begin
              len_d = data_i;
              st_d  = S_XCODE;
            end
            S_XCODE: begin
              if (data_i == X_SYNC && len_q == X_SYNC_LEN)      st_d = S_XPER;
              else if (data_i == X_WIDE && len_q == X_WIDE_LEN) st_d = S_XWID;
              else                                              rej  = 1'b1;
            end
            S_XPER: begin
              per_d = data_i;
              st_d  = S_XOFS;
            end
            S_XOFS: begin
              sync_d = 1'b1;
              sper_d = per_q;
              sofs_d = data_i;
            end
            default: begin
              wide_d = 1'b1;
              wexp_d = data_i;
            end
          endcase
        end
      end
    endcase
    if (rej) begin
      srej_d  = 1'b1;
      atn_d   = 1'b1;
      rvld_d  = 1'b1;
      reply_d = C_REJECT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_FIRST; first_q <= '0; len_q <= '0; per_q <= '0; tcl_q <= '0;
      reply_q <= '0; itcl_q <= '0; tag_q <= '0; sper_q <= '0; sofs_q <= '0; wexp_q <= '0;
      ack_q <= 1'b0; atn_q <= 1'b0; rvld_q <= 1'b0;
      done_q <= 1'b0; disc_q <= 1'b0; save_q <= 1'b0; rest_q <= 1'b0;
      rejin_q <= 1'b0; ident_q <= 1'b0; sync_q <= 1'b0; wide_q <= 1'b0;
      srej_q <= 1'b0; abort_q <= 1'b0; pmis_q <= 1'b0;
    end else begin
      st_q <= st_d; first_q <= first_d; len_q <= len_d; per_q <= per_d; tcl_q <= tcl_d;
      reply_q <= reply_d; itcl_q <= itcl_d; tag_q <= tag_d;
      sper_q <= sper_d; sofs_q <= sofs_d; wexp_q <= wexp_d;
      ack_q <= ack_d; atn_q <= atn_d; rvld_q <= rvld_d;
      done_q <= done_d; disc_q <= disc_d; save_q <= save_d; rest_q <= rest_d;
      rejin_q <= rejin_d; ident_q <= ident_d; sync_q <= sync_d; wide_q <= wide_d;
      srej_q <= srej_d; abort_q <= abort_d; pmis_q <= pmis_d;
    end
  end

  assign ack_o          = ack_q;
  assign atn_o          = atn_q;
  assign reply_vld_o    = rvld_q;
  assign reply_byte_o   = reply_q;
  assign first_byte_o   = first_q;
  assign ev_done_o      = done_q;
  assign ev_disc_o      = disc_q;
  assign ev_save_o      = save_q;
  assign ev_restore_o   = rest_q;
  assign ev_rej_in_o    = rejin_q;
  assign ev_ident_o     = ident_q;
  assign ident_tcl_o    = itcl_q;
  assign tag_o          = tag_q;
  assign ev_sync_o      = sync_q;
  assign sync_period_o  = sper_q;
  assign sync_offset_o  = sofs_q;
  assign ev_wide_o      = wide_q;
  assign wide_exp_o     = wexp_q;
  assign ev_send_rej_o  = srej_q;
  assign ev_abort_tag_o = abort_q;
  assign ev_phase_mis_o = pmis_q;
endmodule

// File: rtl/msgin_decoder_chk.sv
module msgin_decoder_chk #(
  parameter int TAG_SLOTS = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic       phase_mis_i,
  input logic       ack_o,
  input logic       atn_o,
  input logic       reply_vld_o,
  input logic [7:0] reply_byte_o,
  input logic       ev_done_o,
  input logic       ev_disc_o,
  input logic       ev_save_o,
  input logic       ev_restore_o,
  input logic       ev_rej_in_o,
  input logic       ev_ident_o,
  input logic [7:0] tag_o,
  input logic       ev_sync_o,
  input logic       ev_wide_o,
  input logic       ev_send_rej_o,
  input logic       ev_abort_tag_o,
  input logic       ev_phase_mis_o
);
  // R1
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_done_o, ev_disc_o, ev_save_o, ev_restore_o, ev_rej_in_o, ev_ident_o,
              ev_sync_o, ev_wide_o, ev_send_rej_o, ev_abort_tag_o, ev_phase_mis_o}));

  // R1
  done_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done_o || ev_disc_o || ev_save_o || ev_restore_o || ev_rej_in_o) |-> ack_o);

  // R8
  reject_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_send_rej_o |-> (atn_o && reply_vld_o && reply_byte_o == 8'h07));

  // R8
  reply_with_atn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reply_vld_o |-> atn_o);

  // R4
  abort_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort_tag_o |-> (atn_o && reply_vld_o && reply_byte_o == 8'h0D && !ev_ident_o));

  // R4
  tag_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ident_o && tag_o != 8'hFF) |-> (int'(tag_o) < TAG_SLOTS));

  // R9
  ack_spaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  // R9
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(req_i));

  // R10
  pmis_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_phase_mis_o |-> (!ack_o && $past(phase_mis_i)));
endmodule

bind msgin_decoder msgin_decoder_chk #(.TAG_SLOTS(TAG_SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .phase_mis_i(phase_mis_i),
  .ack_o(ack_o), .atn_o(atn_o), .reply_vld_o(reply_vld_o), .reply_byte_o(reply_byte_o),
  .ev_done_o(ev_done_o), .ev_disc_o(ev_disc_o), .ev_save_o(ev_save_o),
  .ev_restore_o(ev_restore_o), .ev_rej_in_o(ev_rej_in_o), .ev_ident_o(ev_ident_o),
  .tag_o(tag_o), .ev_sync_o(ev_sync_o), .ev_wide_o(ev_wide_o),
  .ev_send_rej_o(ev_send_rej_o), .ev_abort_tag_o(ev_abort_tag_o),
  .ev_phase_mis_o(ev_phase_mis_o)
);

// File: tb/msgin_decoder_tb.sv
module msgin_decoder_tb_top;
  logic       clk, rst_n, req_i, phase_mis_i, bus_free_i, chan_b_i;
  logic [7:0] data_i;
  logic [3:0] resel_id_i;
  logic       ack_o, atn_o, reply_vld_o;
  logic [7:0] reply_byte_o, first_byte_o, ident_tcl_o, tag_o;
  logic [7:0] sync_period_o, sync_offset_o, wide_exp_o;
  logic       ev_done_o, ev_disc_o, ev_save_o, ev_restore_o, ev_rej_in_o, ev_ident_o;
  logic       ev_sync_o, ev_wide_o, ev_send_rej_o, ev_abort_tag_o, ev_phase_mis_o;

  msgin_decoder #(.TAG_SLOTS(32)) dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    int         kind;
    logic [7:0] a;
    logic [7:0] b;
    string      rq;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input logic [7:0] a, input logic [7:0] b, input string rq);
    item_t it;
    it.kind = kind; it.a = a; it.b = b; it.rq = rq;
    exp_q.push_back(it);
  endtask

  task automatic got_ev(input int kind, input logic [7:0] a, input logic [7:0] b);
    item_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "unexpected event", {8'(kind), a}, 16'h0);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == kind && e.a == a && e.b == b, e.rq,
          {8'(kind), a ^ b}, {8'(e.kind), e.a ^ e.b});
      if (e.kind == kind && (e.a != a || e.b != b))
        $display("  detail %s a=%h/%h b=%h/%h", e.rq, a, e.a, b, e.b);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ev_done_o)      got_ev(1, 8'h0, 8'h0);
      if (ev_disc_o)      got_ev(2, 8'h0, 8'h0);
      if (ev_save_o)      got_ev(3, 8'h0, 8'h0);
      if (ev_restore_o)   got_ev(4, 8'h0, 8'h0);
      if (ev_rej_in_o)    got_ev(5, 8'h0, 8'h0);
      if (ev_ident_o)     got_ev(6, ident_tcl_o, tag_o);
      if (ev_sync_o)      got_ev(7, sync_period_o, sync_offset_o);
      if (ev_wide_o)      got_ev(8, wide_exp_o, 8'h0);
      if (ev_send_rej_o)  got_ev(9, reply_vld_o ? reply_byte_o : 8'hEE, {7'h0, atn_o});
      if (ev_abort_tag_o) got_ev(10, reply_vld_o ? reply_byte_o : 8'hEE, {7'h0, atn_o});
      if (ev_phase_mis_o) got_ev(11, 8'h0, 8'h0);
    end
  end

  task automatic send(input logic [7:0] b, input string rq);
    bit got;
    got = 1'b0;
    @(negedge clk);
    req_i  = 1'b1;
    data_i = b;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (ack_o) begin
        got = 1'b1;
        break;
      end
    end
    req_i = 1'b0;
    // R9: each byte taken is acknowledged
    chk(got, rq, {15'h0, got}, 16'h1);
  endtask

  task automatic pulse_pm(input bit busfree);
    @(negedge clk);
    if (busfree) bus_free_i = 1'b1; else phase_mis_i = 1'b1;
    @(negedge clk);
    bus_free_i  = 1'b0;
    phase_mis_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit seen;
    rst_n = 1'b0; req_i = 1'b0; data_i = '0; phase_mis_i = 1'b0; bus_free_i = 1'b0;
    resel_id_i = 4'h5; chan_b_i = 1'b1;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!ack_o && !atn_o && !reply_vld_o && !ev_done_o && !ev_ident_o && !ev_send_rej_o,
        "R12 outputs idle", {ack_o, atn_o, reply_vld_o}, 3'b000);
    chk(first_byte_o == 8'h00, "R12 first byte", first_byte_o, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: simple one-byte messages
    expect_ev(1, 0, 0, "R1 done");    send(8'h00, "R1 ack done");
    expect_ev(2, 0, 0, "R1 disc");    send(8'h04, "R1 ack disc");
    expect_ev(3, 0, 0, "R1 save");    send(8'h02, "R1 ack save");
    expect_ev(4, 0, 0, "R1 restore"); send(8'h03, "R1 ack restore");
    chk(first_byte_o == 8'h03, "R11 first byte held", first_byte_o, 8'h03);
    expect_ev(5, 0, 0, "R1 reject in"); send(8'h07, "R1 ack rej");

    // R8: unknown first byte
    expect_ev(9, 8'h07, 8'h01, "R8 unknown rejected"); send(8'h05, "R8 ack");
    chk(first_byte_o == 8'h05, "R11 first byte unknown", first_byte_o, 8'h05);

    // R2 + R4: identify with in-range tag (TCL = {5,1,3} = 0x5B)
    expect_ev(6, 8'h5B, 8'h1F, "R2 R4 ident tag 1F");
    send(8'h83, "R2 ack ident"); send(8'h20, "R3 ack tag msg"); send(8'h1F, "R4 ack tag");

    // R2: reserved bit set
    expect_ev(9, 8'h07, 8'h01, "R2 reserved rejected"); send(8'hC1, "R2 ack rsvd");

    // R3: non-tag byte after identify is re-decoded
    expect_ev(6, 8'h59, 8'hFF, "R3 ident no tag");
    expect_ev(2, 0, 0, "R3 redecoded disc");
    send(8'h81, "R3 ack ident"); send(8'h04, "R3 ack redecoded");
    chk(first_byte_o == 8'h04, "R11 redecoded first", first_byte_o, 8'h04);

    // R3: bus free and phase mismatch during snoop
    expect_ev(6, 8'h5A, 8'hFF, "R3 ident busfree");
    send(8'h82, "R3 ack ident bf"); pulse_pm(1'b1);
    chan_b_i = 1'b0;
    expect_ev(6, 8'h54, 8'hFF, "R3 ident phase change");
    send(8'h84, "R3 ack ident pm"); pulse_pm(1'b0);

    // R4: out-of-range tag and tag 0 boundary
    expect_ev(10, 8'h0D, 8'h01, "R4 abort tag");
    send(8'h80, "R4 ack ident"); send(8'h20, "R4 ack tagmsg"); send(8'h20, "R4 ack bad tag");
    expect_ev(6, 8'h50, 8'h00, "R4 tag zero");
    send(8'h80, "R4 ack ident0"); send(8'h20, "R4 ack tagmsg0"); send(8'h00, "R4 ack tag0");

    // R5: sync negotiation
    expect_ev(7, 8'h19, 8'h0F, "R5 sync params");
    send(8'h01, "R5 a"); send(8'h03, "R5 b"); send(8'h01, "R5 c");
    send(8'h19, "R5 d"); send(8'h0F, "R5 e");

    // R6: wide negotiation
    expect_ev(8, 8'h01, 8'h00, "R6 wide param");
    send(8'h01, "R6 a"); send(8'h02, "R6 b"); send(8'h03, "R6 c"); send(8'h01, "R6 d");

    // R7: length/code mismatches
    expect_ev(9, 8'h07, 8'h01, "R7 sync wrong len");
    send(8'h01, "R7 a"); send(8'h02, "R7 b"); send(8'h01, "R7 c");
    expect_ev(9, 8'h07, 8'h01, "R7 wide wrong len");
    send(8'h01, "R7 d"); send(8'h03, "R7 e"); send(8'h03, "R7 f");
    expect_ev(9, 8'h07, 8'h01, "R7 unknown code");
    send(8'h01, "R7 g"); send(8'h03, "R7 h"); send(8'h05, "R7 i");

    // R10: phase change in the middle of an extended message
    expect_ev(11, 0, 0, "R10 phase mismatch");
    send(8'h01, "R10 ack ext");
    seen = 1'b0;
    @(negedge clk); phase_mis_i = 1'b1;
    @(negedge clk); phase_mis_i = 1'b0; seen = seen | ack_o;
    @(negedge clk); seen = seen | ack_o;
    chk(!seen, "R10 no ack on mismatch", {15'h0, seen}, 16'h0);
    // back to first-byte decoding
    expect_ev(1, 0, 0, "R10 recovers"); send(8'h00, "R10 ack");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "all events seen", 16'(exp_q.size()), 16'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule